// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Access

This block gathers up to 32 interrupt request lines and turns them into a single interrupt output for a processor. Each line is synchronised and then latched into a status bit. A build-time mask makes each line either edge-triggered, latching on a rising edge, or level-triggered, latching while the line is high. A per-line enable masks status into a pending set. A two-bit master control gates the output and governs software-raised requests.

Software reaches the block over a plain 32-bit word bus with a write strobe and combinational read data. Besides a directly writable enable register, two alias registers set or clear enable bits without a read-modify-write. Requests are cleared by writing ones to an acknowledge register. A vector register names the lowest-numbered line that is both latched and enabled, or reads as all-ones when there is none. The bus uses word indices, so byte offset = 4 × word index.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, status, enable and both master control bits read zero, the output `irq_out` is low and the vector (word 6) reads 0xFFFFFFFF.
- R2: A level-type line (EDGE_MASK bit 0) held high sets its status bit (word 0). The bit stays set after the line drops, until it is acknowledged. If the line is still high when it is acknowledged, the bit reads 0 in the cycle after the acknowledge and is set again one cycle later.
- R3: An edge-type line (EDGE_MASK bit 1) sets its status bit on a rising edge of the synchronised line. The bit stays set after the line falls. Once it is acknowledged, it stays clear while the line is held high.
- R4: A write to word 2 loads the enable bits. A write to word 4 sets the enable bits written as 1. A write to word 5 clears the enable bits written as 1. Zero bits in a word 4 or word 5 write change nothing.
- R5: Word 1 reads the bitwise AND of status and enable.
- R6: `irq_out` is high exactly when master bit 0 (word 7, bit 0) is 1 and at least one pending bit is set.
- R7: Word 6 reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R8: A write to word 3 clears each status bit written as 1 and leaves the other status bits unchanged. Writing all-ones clears every status bit.
- R9: While word 7 bit 1 is 0, a write to word 0 sets the status bits written as 1. Once word 7 bit 1 is 1, writes to word 0 are ignored, and bit 1 cannot be cleared by a write. Only reset clears it.
- R10: Words 3, 4 and 5 read as zero. Word 7 reads bit 1 and bit 0 of the master control, with zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Interrupt request lines |
| bus_word | input | 3 | Word index of the register accessed |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_word` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with eight lines and an edge mask of 0xF0. This gives four level-type lines (0 to 3) and four edge-type lines (4 to 7), so both latching behaviours can be tested side by side. With eight lines, software-raised status bits can place requests at chosen positions, which is enough to show that the vector reports the lowest pending line. It also lets the tests show how the vector changes as enables and acknowledges alter the pending set. The synchroniser keeps its default depth of two, so the bench waits a fixed number of cycles after driving a line before it reads the status.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // Register word indices (byte offset = index * 4)
    typedef enum logic [2:0] {
        W_STATUS = 3'd0,
        W_PEND   = 3'd1,
        W_ENABLE = 3'd2,
        W_ACK    = 3'd3,
        W_SETEN  = 3'd4,
        W_CLREN  = 3'd5,
        W_VECTOR = 3'd6,
        W_MASTER = 3'd7
    } reg_word_e;

    localparam int unsigned BUS_W = 32;
    localparam logic [BUS_W-1:0] NO_VECTOR = '1;

endpackage

// File: rtl/irqv_sync_edge.sv
module irqv_sync_edge #(
    parameter int unsigned N_IRQ     = 32,
    parameter int unsigned STAGES    = 2,
    parameter logic [N_IRQ-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    output logic [N_IRQ-1:0] hit
);

    typedef struct packed {
        logic [STAGES-1:0][N_IRQ-1:0] sync;
        logic [N_IRQ-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic [N_IRQ-1:0] line_s;

    assign line_s = st_q.sync[STAGES-1];

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = irq_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.sync[k] = st_q.sync[k-1];
        end
        st_d.prev = line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = line_s[i] & ~st_q.prev[i];
        end else begin : g_level
            assign hit[i] = line_s[i];
        end
    end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
    parameter int unsigned N_IRQ = 32,
    localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0] pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqv_read_mux.sv
module irqv_read_mux
    import irqv_pkg::*;
#(
    parameter int unsigned N_IRQ = 32
) (
    input  logic [2:0]       word,
    input  logic [N_IRQ-1:0] status,
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] enable,
    input  logic [BUS_W-1:0] vector,
    input  logic             master_on,
    input  logic             hw_lock,
    output logic [BUS_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (reg_word_e'(word))
            W_STATUS: rdata = BUS_W'(status);
            W_PEND:   rdata = BUS_W'(pend);
            W_ENABLE: rdata = BUS_W'(enable);
            W_VECTOR: rdata = vector;
            W_MASTER: rdata = {{(BUS_W-2){1'b0}}, hw_lock, master_on};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned N_IRQ       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [N_IRQ-1:0] EDGE_MASK = '0,
    localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [2:0]       bus_word,
    input  logic             bus_wen,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_out
);

    typedef struct packed {
        logic [N_IRQ-1:0] status;
        logic [N_IRQ-1:0] enable;
        logic             master_on;
        logic             hw_lock;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [N_IRQ-1:0] hw_hit;
    logic [N_IRQ-1:0] pend;
    logic [N_IRQ-1:0] set_mask;
    logic [N_IRQ-1:0] ack_mask;
    logic [N_IRQ-1:0] wbits;
    logic             vec_found;
    logic [IDX_W-1:0] vec_idx;
    logic [BUS_W-1:0] vector;

    irqv_sync_edge #(
        .N_IRQ     (N_IRQ),
        .STAGES    (SYNC_STAGES),
        .EDGE_MASK (EDGE_MASK)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .hit    (hw_hit)
    );

    assign wbits = bus_wdata[N_IRQ-1:0];
    assign pend  = st_q.status & st_q.enable;

    irqv_prio_enc #(
        .N_IRQ (N_IRQ)
    ) prio_i (
        .pend  (pend),
        .found (vec_found),
        .idx   (vec_idx)
    );

    assign vector  = vec_found ? BUS_W'(vec_idx) : NO_VECTOR;
    assign irq_out = st_q.master_on & (|pend);

    always_comb begin
        st_d     = st_q;
        set_mask = hw_hit;
        ack_mask = '0;
        if (bus_wen) begin
            case (reg_word_e'(bus_word))
                W_STATUS: if (!st_q.hw_lock) set_mask = hw_hit | wbits;
                W_ENABLE: st_d.enable = wbits;
                W_ACK:    ack_mask = wbits;
                W_SETEN:  st_d.enable = st_q.enable | wbits;
                W_CLREN:  st_d.enable = st_q.enable & ~wbits;
                W_MASTER: begin
                    st_d.master_on = bus_wdata[0];
                    st_d.hw_lock   = st_q.hw_lock | bus_wdata[1];
                end
                default: ;
            endcase
        end
        // acknowledge wins over a request arriving in the same cycle
        st_d.status = (st_q.status | set_mask) & ~ack_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irqv_read_mux #(
        .N_IRQ (N_IRQ)
    ) rmux_i (
        .word      (bus_word),
        .status    (st_q.status),
        .pend      (pend),
        .enable    (st_q.enable),
        .vector    (vector),
        .master_on (st_q.master_on),
        .hw_lock   (st_q.hw_lock),
        .rdata     (bus_rdata)
    );

    // R9
    hw_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hw_lock |=> st_q.hw_lock);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_word == W_ACK) |=> ((st_q.status & $past(wbits)) == '0));

    // R2 R3: a status bit only drops after an acknowledge of that bit
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q.status & $past(st_q.status) & ~$past(ack_mask)) == '0));

    // R4
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_word == W_SETEN) |=> ((st_q.enable & $past(wbits)) == $past(wbits)));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_word == W_CLREN) |=> ((st_q.enable & $past(wbits)) == '0));

    // R7
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_found |-> (pend[vec_idx] &&
            ((pend & ((N_IRQ'(1) << vec_idx) - N_IRQ'(1))) == '0)));

    // R6
    out_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend != '0));

endmodule

// File: tb/irqv_ctrl_tb_top.sv
module irqv_ctrl_tb_top;

    localparam int unsigned N = 8;
    localparam logic [N-1:0] EMASK = 8'hF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [2:0]    bus_word = '0;
    logic          bus_wen = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqv_ctrl #(
        .N_IRQ       (N),
        .SYNC_STAGES (2),
        .EDGE_MASK   (EMASK)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_word  (bus_word),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_word  = w;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] w, input logic [31:0] exp);
        bus_word = w;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 3'd0, 32'h0);
        rd_chk("R1 enable", 3'd2, 32'h0);
        rd_chk("R1 master", 3'd7, 32'h0);
        rd_chk("R1 vector", 3'd6, 32'hFFFF_FFFF);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_enable;
        wr(3'd2, 32'h0F); rd_chk("R4 direct load", 3'd2, 32'h0F);
        wr(3'd4, 32'h30); rd_chk("R4 set alias", 3'd2, 32'h3F);
        wr(3'd4, 32'h00); rd_chk("R4 set zero no effect", 3'd2, 32'h3F);
        wr(3'd5, 32'h05); rd_chk("R4 clear alias", 3'd2, 32'h3A);
        wr(3'd5, 32'h00); rd_chk("R4 clear zero no effect", 3'd2, 32'h3A);
        rd_chk("R10 ack reads zero", 3'd3, 32'h0);
        rd_chk("R10 set alias reads zero", 3'd4, 32'h0);
        rd_chk("R10 clear alias reads zero", 3'd5, 32'h0);
        wr(3'd2, 32'h00); rd_chk("R4 direct clear", 3'd2, 32'h0);
    endtask

    task automatic t_level;
        irq_in[2] = 1'b1;
        idle(5);
        rd_chk("R2 level latched", 3'd0, 32'h04);
        wr(3'd3, 32'h04);
        rd_chk("R2 cleared right after ack", 3'd0, 32'h00);
        idle(1);
        rd_chk("R2 re-latched while held", 3'd0, 32'h04);
        irq_in[2] = 1'b0;
        idle(5);
        rd_chk("R2 held after drop", 3'd0, 32'h04);
        wr(3'd3, 32'h04);
        idle(3);
        rd_chk("R2 clear after drop and ack", 3'd0, 32'h00);
    endtask

    task automatic t_edge;
        irq_in[5] = 1'b1;
        idle(2);
        irq_in[5] = 1'b0;
        idle(5);
        rd_chk("R3 edge latched and held after fall", 3'd0, 32'h20);
        irq_in[6] = 1'b1;
        idle(5);
        rd_chk("R3 second edge latched", 3'd0, 32'h60);
        wr(3'd3, 32'h40);
        idle(4);
        rd_chk("R3 no re-latch while held", 3'd0, 32'h20);
        irq_in[6] = 1'b0;
        wr(3'd3, 32'hFF);
        idle(3);
        rd_chk("R8 all-ones ack clears all", 3'd0, 32'h00);
    endtask

    task automatic t_pend_vector;
        wr(3'd0, 32'h28);
        rd_chk("R9 software set before lock", 3'd0, 32'h28);
        wr(3'd7, 32'h1);
        rd_chk("R5 pending none enabled", 3'd1, 32'h00);
        rd_chk("R7 vector none pending", 3'd6, 32'hFFFF_FFFF);
        chk("R6 no pending no output", {31'b0, irq_out}, 32'h0);
        wr(3'd2, 32'h20);
        rd_chk("R5 pending one", 3'd1, 32'h20);
        rd_chk("R7 vector single", 3'd6, 32'd5);
        chk("R6 output raised", {31'b0, irq_out}, 32'h1);
        wr(3'd4, 32'h08);
        rd_chk("R7 vector lowest wins", 3'd6, 32'd3);
        wr(3'd7, 32'h0);
        chk("R6 master off gates output", {31'b0, irq_out}, 32'h0);
        rd_chk("R5 pending kept with master off", 3'd1, 32'h28);
        wr(3'd7, 32'h1);
        wr(3'd3, 32'h08);
        rd_chk("R8 partial ack", 3'd0, 32'h20);
        rd_chk("R7 vector after ack", 3'd6, 32'd5);
        wr(3'd3, 32'hFF);
        rd_chk("R7 vector empty again", 3'd6, 32'hFFFF_FFFF);
        chk("R6 output dropped", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_lock;
        wr(3'd7, 32'h3);
        rd_chk("R10 master readback", 3'd7, 32'h3);
        wr(3'd0, 32'h01);
        rd_chk("R9 software set ignored after lock", 3'd0, 32'h00);
        wr(3'd7, 32'h0);
        rd_chk("R9 lock bit survives write", 3'd7, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_pend_vector();
        t_lock();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule